// File: doc/BRIEF.md
# Inductive Boost Switch Phase Sequencer

This block sets the gate enables of an inductive boost converter that charges a card supply rail. It runs two phases in turn. In the charge phase the charge switch pair stores energy in the inductor. The charge phase ends when the peak-current comparator trips, or when a cycle-count limit runs out. In the transfer phase the transfer switch pair delivers that energy to the output for a fixed number of cycles. The comparators, current sensing and the power stage are outside this block; it sees them only as digital flags.

The output-below-target flag controls regulation. If the flag is still high when a transfer phase ends, another charge phase starts. When the flag drops during a transfer, the transfer pair turns off and the clamp pair turns on, so that residual inductor current drains. The clamp stays on until the output sags below target again. When the programmed level is off or no card is present, every switch pair is turned off and the output pull-down is enabled. Any change from one switch pair to another passes through one dead cycle in which no pair is on.

Top module: `boost_phase_seq`

## Requirements
- R1: While in the charge phase, only `chg_en` is high, and `xfr_en`, `clmp_en` and `pd_en` are low.
- R2: If `pk_hit` is high on a clock edge during the charge phase, `chg_en` is low from the next cycle, which is a dead cycle, and the cycle after that begins the transfer phase.
- R3: With no `pk_hit`, a charge phase lasts exactly CHG_CYC cycles (4000 ns at CLK_HZ, which is 200 cycles at the defaults) and is then followed by a dead cycle and a transfer phase.
- R4: During the transfer phase, only `xfr_en` is high. With `out_low` held high, the transfer phase lasts exactly XFR_CYC cycles (900 ns, which is 45 cycles at the defaults).
- R5: If `out_low` is still high when a transfer phase completes, one dead cycle follows and then a new charge phase begins.
- R6: If `out_low` is low on an edge during the transfer phase, `xfr_en` is low from the next cycle. That cycle is a dead cycle, and after it only `clmp_en` is high.
- R7: The clamp state is held while `out_low` stays low. Once `out_low` is high, one dead cycle follows and then a charge phase begins.
- R8: `level` codes 0=off, 1=1.8 V, 2=3.0 V and 3=5.0 V. Any of codes 1, 2 or 3 with `card_in` high enables the converter. If `level` is 0 or `card_in` is low on an edge, then from the next cycle only `pd_en` is high, whatever the phase.
- R9: At most one of `chg_en`, `xfr_en` and `clmp_en` is high in any cycle. A pair that was on in one cycle is never followed directly by a different pair in the next cycle.
- R10: A synchronous active-high `rst` gives all four enables low in the cycle after the reset edge, with the sequencer in the disabled state.
- R11: When the converter becomes enabled, one dead cycle follows. The next state is the charge phase if `out_low` was high, or the clamp state otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pk_hit | input | 1 | Inductor current has reached its peak |
| out_low | input | 1 | Output is below its programmed target |
| level | input | 2 | Programmed output level, 0 = off |
| card_in | input | 1 | Card present |
| chg_en | output | 1 | Charge switch pair enable |
| xfr_en | output | 1 | Transfer switch pair enable |
| clmp_en | output | 1 | Inductor clamp pair enable |
| pd_en | output | 1 | Output pull-down enable |

## Verification
The hardest situation to reach is the charge timeout, because it needs `pk_hit` to stay low for the full 200-cycle window. The stimulus holds `pk_hit` low through one complete charge phase and counts how many cycles the charge enable stays high. The early exits use a different method: `pk_hit` or a falling `out_low` is raised after a counted number of observed phase cycles, so each exit lands on a known cycle. Disabling during an active phase is covered by pulling `card_in` low in the middle of a charge phase.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic [2:0] {
        PH_OFF  = 3'd0,
        PH_GAP  = 3'd1,
        PH_CHG  = 3'd2,
        PH_XFR  = 3'd3,
        PH_CLMP = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e ph;
        phase_e after;
    } seq_s;

    localparam int NUM_GATES = 4;

    function automatic phase_e gate_phase(input int idx);
        case (idx)
            0:       return PH_CLMP;
            1:       return PH_XFR;
            2:       return PH_CHG;
            default: return PH_OFF;
        endcase
    endfunction

    function automatic int ns_to_cycles(input longint hz, input longint ns);
        longint c;
        c = (hz * ns) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/bps_enable_qual.sv
module bps_enable_qual #(
    parameter int LVL_W = 2
) (
    input  logic [LVL_W-1:0] level,
    input  logic             card_in,
    output logic             run_ok
);
    always_comb begin
        run_ok = card_in && (level != '0);
    end
endmodule

// File: rtl/bps_phase_timer.sv
module bps_phase_timer #(
    parameter int CHG_CYC = 200,
    parameter int XFR_CYC = 45,
    parameter int CNT_W   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic chg_expired,
    output logic xfr_expired
);
    localparam int          TOP_CYC = (CHG_CYC > XFR_CYC) ? CHG_CYC : XFR_CYC;
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TOP_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart)
            cnt_d = '0;
        else if (cnt_q == CNT_SAT)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
        chg_expired = (cnt_q == CNT_W'(CHG_CYC - 1));
        xfr_expired = (cnt_q == CNT_W'(XFR_CYC - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bps_gate_drive.sv
module bps_gate_drive
    import bps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  phase_e               ph_d,
    output logic [NUM_GATES-1:0] gate_q
);
    logic [NUM_GATES-1:0] gate_d;

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        always_comb begin
            gate_d[g] = (ph_d == gate_phase(g));
        end
        always_ff @(posedge clk) begin
            if (rst) gate_q[g] <= 1'b0;
            else     gate_q[g] <= gate_d[g];
        end
    end
endmodule

// File: rtl/boost_phase_seq.sv
module boost_phase_seq
    import bps_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int CHG_LIMIT_NS = 4000,
    parameter int XFR_TIME_NS  = 900,
    parameter int LVL_W        = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pk_hit,
    input  logic             out_low,
    input  logic [LVL_W-1:0] level,
    input  logic             card_in,
    output logic             chg_en,
    output logic             xfr_en,
    output logic             clmp_en,
    output logic             pd_en
);
    localparam int CHG_CYC = ns_to_cycles(CLK_HZ, CHG_LIMIT_NS);
    localparam int XFR_CYC = ns_to_cycles(CLK_HZ, XFR_TIME_NS);
    localparam int TOP_CYC = (CHG_CYC > XFR_CYC) ? CHG_CYC : XFR_CYC;
    localparam int CNT_W   = $clog2(TOP_CYC + 1);

    seq_s s_d, s_q;
    logic run_ok;
    logic restart;
    logic chg_expired, xfr_expired;
    logic [NUM_GATES-1:0] gate_q;

    bps_enable_qual #(.LVL_W(LVL_W)) qual_i (
        .level   (level),
        .card_in (card_in),
        .run_ok  (run_ok)
    );

    bps_phase_timer #(.CHG_CYC(CHG_CYC), .XFR_CYC(XFR_CYC), .CNT_W(CNT_W)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .chg_expired (chg_expired),
        .xfr_expired (xfr_expired)
    );

    always_comb begin
        s_d = s_q;
        if (!run_ok) begin
            s_d.ph = PH_OFF;
        end else begin
            case (s_q.ph)
                PH_OFF: begin
                    s_d.ph    = PH_GAP;
                    s_d.after = out_low ? PH_CHG : PH_CLMP;
                end
                PH_GAP: begin
                    s_d.ph = s_q.after;
                end
                PH_CHG: begin
                    if (pk_hit || chg_expired) begin
                        s_d.ph    = PH_GAP;
                        s_d.after = PH_XFR;
                    end
                end
                PH_XFR: begin
                    if (!out_low) begin
                        s_d.ph    = PH_GAP;
                        s_d.after = PH_CLMP;
                    end else if (xfr_expired) begin
                        s_d.ph    = PH_GAP;
                        s_d.after = PH_CHG;
                    end
                end
                PH_CLMP: begin
                    if (out_low) begin
                        s_d.ph    = PH_GAP;
                        s_d.after = PH_CHG;
                    end
                end
                default: begin
                    s_d.ph = PH_OFF;
                end
            endcase
        end
        restart = (s_d.ph != s_q.ph);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.ph    <= PH_OFF;
            s_q.after <= PH_OFF;
        end else begin
            s_q <= s_d;
        end
    end

    bps_gate_drive gate_i (
        .clk    (clk),
        .rst    (rst),
        .ph_d   (s_d.ph),
        .gate_q (gate_q)
    );

    always_comb begin
        clmp_en = gate_q[0];
        xfr_en  = gate_q[1];
        chg_en  = gate_q[2];
        pd_en   = gate_q[3];
    end
endmodule

// File: rtl/bps_chk.sv
module bps_chk #(
    parameter int CHG_CYC = 200,
    parameter int LVL_W   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             pk_hit,
    input logic             out_low,
    input logic [LVL_W-1:0] level,
    input logic             card_in,
    input logic             chg_en,
    input logic             xfr_en,
    input logic             clmp_en,
    input logic             pd_en
);
    int chg_run;

    always_ff @(posedge clk) begin
        if (rst)         chg_run <= 0;
        else if (chg_en) chg_run <= chg_run + 1;
        else             chg_run <= 0;
    end

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (!chg_en && !xfr_en && !clmp_en && !pd_en));

    assert_one_pair_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({chg_en, xfr_en, clmp_en}) <= 1);

    assert_dead_after_chg_R9: assert property (@(posedge clk) disable iff (rst)
        chg_en |=> (!xfr_en && !clmp_en));

    assert_dead_after_xfr_R9: assert property (@(posedge clk) disable iff (rst)
        xfr_en |=> (!chg_en && !clmp_en));

    assert_dead_after_clmp_R9: assert property (@(posedge clk) disable iff (rst)
        clmp_en |=> (!chg_en && !xfr_en));

    assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
        (!card_in || level == '0) |=> (pd_en && !chg_en && !xfr_en && !clmp_en));

    assert_peak_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (chg_en && pk_hit) |=> !chg_en);

    assert_reached_R6: assert property (@(posedge clk) disable iff (rst)
        (xfr_en && !out_low) |=> !xfr_en);

    assert_timeout_R3: assert property (@(posedge clk) disable iff (rst)
        chg_en |-> (chg_run < CHG_CYC));
endmodule

bind boost_phase_seq bps_chk #(.CHG_CYC(CHG_CYC), .LVL_W(LVL_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .pk_hit  (pk_hit),
    .out_low (out_low),
    .level   (level),
    .card_in (card_in),
    .chg_en  (chg_en),
    .xfr_en  (xfr_en),
    .clmp_en (clmp_en),
    .pd_en   (pd_en)
);

// File: tb/boost_phase_seq_tb_top.sv
module boost_phase_seq_tb_top;
    localparam int CHG_CYC = 200;
    localparam int XFR_CYC = 45;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pk_hit = 1'b0;
    logic out_low = 1'b1;
    logic [1:0] level = 2'd0;
    logic card_in = 1'b1;
    logic chg_en, xfr_en, clmp_en, pd_en;
    logic [3:0] outs;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model: 0 off, 1 dead, 2 charge, 3 transfer, 4 clamp
    int m_ph = 0;
    int m_after = 0;
    int m_t = 0;
    bit m_rst = 1'b1;

    always #10 clk = ~clk;

    boost_phase_seq dut_i (
        .clk(clk), .rst(rst), .pk_hit(pk_hit), .out_low(out_low),
        .level(level), .card_in(card_in),
        .chg_en(chg_en), .xfr_en(xfr_en), .clmp_en(clmp_en), .pd_en(pd_en)
    );

    assign outs = {chg_en, xfr_en, clmp_en, pd_en};

    task automatic go_dead(input int nxt);
        m_ph = 1; m_after = nxt; m_t = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_rst = 1'b1; m_ph = 0; m_t = 0;
        end else begin
            m_rst = 1'b0;
            if (!(card_in && level != 2'd0)) begin
                m_ph = 0; m_t = 0;
            end else begin
                case (m_ph)
                    0: go_dead(out_low ? 2 : 4);
                    1: begin m_ph = m_after; m_t = 0; end
                    2: if (pk_hit || m_t + 1 >= CHG_CYC) go_dead(3); else m_t++;
                    3: if (!out_low) go_dead(4);
                       else if (m_t + 1 >= XFR_CYC) go_dead(2);
                       else m_t++;
                    default: if (out_low) go_dead(2);
                endcase
            end
        end
    end

    function automatic logic [3:0] model_outs();
        if (m_rst) return 4'b0000;
        case (m_ph)
            0: return 4'b0001;
            2: return 4'b1000;
            3: return 4'b0100;
            4: return 4'b0010;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: outs actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (!done) begin
            string tag;
            case (m_ph)
                0: tag = m_rst ? "R10" : "R8";
                1: tag = "R9";
                2: tag = "R1";
                3: tag = "R4";
                default: tag = "R6";
            endcase
            chk(tag, outs, model_outs());
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R10", outs, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        chk("R8", outs, 4'b0001);
        repeat (2) @(negedge clk);

        // enable with output low: dead cycle then charge (R11)
        level = 2'd2; out_low = 1'b1;
        @(negedge clk); chk("R11", outs, 4'b0000);
        @(negedge clk); chk("R1", outs, 4'b1000);

        // full charge timeout (R3)
        n = 0;
        while (outs[3] && n < 1000) begin n++; @(negedge clk); end
        chk_int("R3", n, CHG_CYC);
        chk("R3", outs, 4'b0000);
        @(negedge clk); chk("R3", outs, 4'b0100);

        // full transfer length (R4) then recharge (R5)
        n = 0;
        while (outs[2] && n < 1000) begin n++; @(negedge clk); end
        chk_int("R4", n, XFR_CYC);
        chk("R5", outs, 4'b0000);
        @(negedge clk); chk("R5", outs, 4'b1000);

        // peak current ends charge after 10 cycles (R2)
        repeat (9) @(negedge clk);
        pk_hit = 1'b1;
        @(negedge clk); chk("R2", outs, 4'b0000);
        pk_hit = 1'b0;
        @(negedge clk); chk("R2", outs, 4'b0100);

        // regulation reached mid-transfer (R6), clamp held (R7)
        repeat (4) @(negedge clk);
        out_low = 1'b0;
        @(negedge clk); chk("R6", outs, 4'b0000);
        @(negedge clk); chk("R6", outs, 4'b0010);
        repeat (20) @(negedge clk);
        chk("R7", outs, 4'b0010);
        out_low = 1'b1;
        @(negedge clk); chk("R7", outs, 4'b0000);
        @(negedge clk); chk("R7", outs, 4'b1000);

        // card removed during charge (R8)
        repeat (5) @(negedge clk);
        card_in = 1'b0;
        @(negedge clk); chk("R8", outs, 4'b0001);
        repeat (3) @(negedge clk);

        // re-enable at 5.0 V with output at target: clamp (R11)
        card_in = 1'b1; level = 2'd3; out_low = 1'b0;
        @(negedge clk); chk("R11", outs, 4'b0000);
        @(negedge clk); chk("R11", outs, 4'b0010);

        // 1.8 V code also enables (R8)
        level = 2'd1; out_low = 1'b1;
        @(negedge clk); chk("R7", outs, 4'b0000);
        @(negedge clk); chk("R8", outs, 4'b1000);
        level = 2'd0;
        @(negedge clk); chk("R8", outs, 4'b0001);
        repeat (5) @(negedge clk);
        finish_up();
    end

    initial begin
        wait (cycles > 150000);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end
endmodule